// File: doc/BRIEF.md
# Read-Once Key Readout Port

This block holds a 256-bit derived key and lets software read it as eight 32-bit words. Every word gives its true value once; after that word has been read, each later read of it returns zero. A new key, loaded through a strobe from the derivation logic upstream, makes every word readable once more.

Software can also set a one-way readout lock. Once the lock is set, no key word can be read until the next reset. Reads made while the lock is set return zero. The lock state can be read back at a control address.

Reads take one clock cycle. The block samples a read request at a clock edge. In the next cycle it presents the data and raises a valid flag. A read consumes its word at that same edge.

Top module: `otr_key_port`

## Requirements
- R1: After reset, rd_valid and rd_data are zero and the lock is clear. Before the first key load, every key word reads as zero.
- R2: Key word i sits at byte address 0x20 + 4*i, for i from 0 to 7. It returns key_in[32*i+31 : 32*i] of the last load. rd_valid and rd_data appear in the cycle after rd_en.
- R3: Only the first read of a key word after a load returns its value. Every later read of that word returns zero, and the other words are not affected.
- R4: A key_load pulse stores key_in and makes all eight words readable once again.
- R5: A write to address 0x4C with wr_data bit 16 set turns on the lock. A read of 0x4C returns the lock in bit 16, with every other bit zero.
- R6: Once the lock is set, only reset clears it. A write to 0x4C with bit 16 clear leaves it set.
- R7: While the lock is set, every key word reads as zero. This holds even after a new key has been loaded, and such reads consume nothing.
- R8: A read in the same cycle as key_load returns the word held before the load, or zero if that word was already consumed. After that, the newly loaded word is still readable once.
- R9: rd_data is zero in every cycle in which rd_valid is low. A read of an address that is not a key word and not 0x4C, including a misaligned address, returns zero with rd_valid high.
- R10: A key read in the same cycle as a write that sets the lock uses the lock state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Strobe that stores key_in |
| key_in | input | 256 | Derived key, word i in bits 32*i+31:32*i |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Byte address of the read |
| rd_valid | output | 1 | Read data is present this cycle |
| rd_data | output | 32 | Read data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |

## Verification
The hardest situations to reach are the ones where two events fall on the same edge. One is a read that collides with a key load. There the old word must come out while the consumed flag is cleared for the new one. The other is a read that collides with the lock being set. The bench drives both requests at the same negative edge, once with the old word unread and once with it already consumed. It then reads again to show which state was kept. Full sweeps over all 256 byte addresses, in rising and falling order, are checked against a consumed model kept in the bench. They cover the address map and the edges of the key window.

// File: rtl/otr_pkg.sv
package otr_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned KEY_WORDS = 8;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] KEY_BASE  = 8'h20;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h4C;
    localparam int unsigned LOCK_POS  = 16;

    // Target of a decoded read
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_CTRL = 2'd2
    } rd_sel_e;

    // Control register image for a given lock state
    function automatic logic [WORD_W-1:0] ctrl_image(input logic lock);
        logic [WORD_W-1:0] v;
        v = '0;
        v[LOCK_POS] = lock;
        return v;
    endfunction
endpackage

// File: rtl/otr_addr_dec.sv
module otr_addr_dec
    import otr_pkg::*;
#(
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned NW    = KEY_WORDS,
    parameter logic [AW-1:0] BASE = KEY_BASE,
    parameter logic [AW-1:0] CTRL = CTRL_ADDR,
    localparam int unsigned IW   = (NW > 1) ? $clog2(NW) : 1,
    localparam int unsigned OW   = AW - 2
) (
    input  logic [AW-1:0] addr,
    output rd_sel_e       sel,
    output logic [IW-1:0] idx
);
    logic [AW-1:0] off;
    logic [OW-1:0] woff;

    always_comb begin
        off  = addr - BASE;
        woff = off[AW-1:2];
        idx  = woff[IW-1:0];
        if ((addr >= BASE) && (off[1:0] == 2'b00) && (woff < OW'(NW)))
            sel = SEL_KEY;
        else if (addr == CTRL)
            sel = SEL_CTRL;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/otr_key_store.sv
module otr_key_store
    import otr_pkg::*;
#(
    parameter int unsigned WW  = WORD_W,
    parameter int unsigned NW  = KEY_WORDS,
    localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NW*WW-1:0]  key_in,
    input  logic              take,
    input  logic [IW-1:0]     idx,
    output logic [WW-1:0]     word_out,
    output logic [NW-1:0]     consumed
);
    logic [WW-1:0] store [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                store[g]    <= '0;
                consumed[g] <= 1'b0;
            end else if (load) begin
                store[g]    <= key_in[g*WW +: WW];
                consumed[g] <= 1'b0;
            end else if (take && (idx == IW'(g))) begin
                consumed[g] <= 1'b1;
            end
        end
    end

    // A consumed word yields zero
    assign word_out = consumed[idx] ? '0 : store[idx];
endmodule

// File: rtl/otr_lock_bit.sv
module otr_lock_bit
    import otr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned WW = WORD_W,
    parameter logic [AW-1:0] CTRL = CTRL_ADDR,
    parameter int unsigned POS = LOCK_POS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    output logic          lock
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Sticky: only reset clears it
    always_ff @(posedge clk) begin
        if (rst)
            lock <= 1'b0;
        else if (wr_en && (wr_addr == CTRL) && wr_data[POS])
            lock <= 1'b1;
    end
endmodule

// File: rtl/otr_key_port.sv
module otr_key_port
    import otr_pkg::*;
#(
    parameter int unsigned WW  = WORD_W,
    parameter int unsigned NW  = KEY_WORDS,
    parameter int unsigned AW  = ADDR_W,
    localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_load,
    input  logic [NW*WW-1:0] key_in,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic [WW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WW-1:0]    wr_data
);
    rd_sel_e       dec_sel;
    logic [IW-1:0] dec_idx;
    logic [WW-1:0] word_out;
    logic [NW-1:0] consumed;
    logic          lock_q;
    logic          take;
    logic [WW-1:0] data_d;

    otr_addr_dec #(.AW(AW), .NW(NW), .BASE(KEY_BASE), .CTRL(CTRL_ADDR)) u_dec (
        .addr(rd_addr), .sel(dec_sel), .idx(dec_idx)
    );

    assign take = rd_en && (dec_sel == SEL_KEY) && !lock_q;

    otr_key_store #(.WW(WW), .NW(NW)) u_store (
        .clk(clk), .rst(rst), .load(key_load), .key_in(key_in),
        .take(take), .idx(dec_idx), .word_out(word_out), .consumed(consumed)
    );

    otr_lock_bit #(.AW(AW), .WW(WW), .CTRL(CTRL_ADDR), .POS(LOCK_POS)) u_lock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock(lock_q)
    );

    always_comb begin
        data_d = '0;
        if (rd_en) begin
            unique case (dec_sel)
                SEL_KEY:  data_d = lock_q ? '0 : word_out;
                SEL_CTRL: data_d = ctrl_image(lock_q);
                default:  data_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= data_d;
        end
    end
endmodule

// File: rtl/otr_key_port_chk.sv
module otr_key_port_chk
    import otr_pkg::*;
#(
    parameter int unsigned WW = WORD_W,
    parameter int unsigned NW = KEY_WORDS,
    parameter int unsigned IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          key_load,
    input logic          lock,
    input logic          rd_valid,
    input logic [WW-1:0] rd_data,
    input rd_sel_e       sel,
    input logic [IW-1:0] idx,
    input logic [NW-1:0] consumed
);
    AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid); // R2
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_en |=> (rd_data == '0)); // R9
    AST_CONSUMED_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && sel == SEL_KEY && consumed[idx]) |=> (rd_data == '0)); // R3
    AST_LOAD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst) key_load |=> (consumed == '0)); // R4
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst) lock |=> lock); // R6
    AST_LOCKED_KEY_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && lock && sel == SEL_KEY) |=> (rd_data == '0)); // R7
    AST_LOCKED_NO_CONSUME: assert property (@(posedge clk) disable iff (rst) (lock && !key_load) |=> $stable(consumed)); // R7
    AST_FLAGS_ONLY_RISE: assert property (@(posedge clk) disable iff (rst) !key_load |=> ((consumed & $past(consumed)) == $past(consumed))); // R3
endmodule

bind otr_key_port otr_key_port_chk #(.WW(WW), .NW(NW), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .key_load(key_load), .lock(lock_q),
    .rd_valid(rd_valid), .rd_data(rd_data), .sel(dec_sel), .idx(dec_idx),
    .consumed(consumed)
);

// File: tb/otr_key_port_test.sv
module otr_key_port_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_load = 1'b0;
    logic [255:0] key_in = '0;
    logic         rd_en = 1'b0;
    logic [7:0]   rd_addr = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [255:0] cur_key = '0;
    bit           got [8];
    bit           locked = 1'b0;

    always #5 clk = ~clk;

    otr_key_port uut (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [255:0] mk_key(input int s);
        logic [255:0] k;
        for (int i = 0; i < 8; i++)
            k[32*i +: 32] = (32'(s * 8 + i + 1) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
        return k;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_key(input logic [255:0] k);
        @(negedge clk);
        key_load = 1'b1; key_in = k;
        @(negedge clk);
        key_load = 1'b0;
        cur_key = k;
        for (int i = 0; i < 8; i++) got[i] = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 8'h4C && d[16]) locked = 1'b1;
    endtask

    // Bench model of one read: updates consumed bookkeeping
    function automatic logic [31:0] model_read(input logic [7:0] a);
        int w;
        if (a[1:0] == 2'b00 && a >= 8'h20 && a < 8'h40) begin
            w = (int'(a) - 32) / 4;
            if (locked) return 32'h0;
            if (got[w]) return 32'h0;
            got[w] = 1'b1;
            return cur_key[32*w +: 32];
        end
        if (a == 8'h4C) return locked ? 32'h0001_0000 : 32'h0;
        return 32'h0;
    endfunction

    task automatic sweep(input bit down, input string req);
        for (int j = 0; j < 256; j++) begin
            logic [7:0] a;
            logic [31:0] e;
            a = down ? 8'(255 - j) : 8'(j);
            e = model_read(a);
            do_read(a, e, req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(rd_valid === 1'b0 && rd_data === 32'h0, "R1", rd_data, 32'h0);
        do_read(8'h4C, 32'h0, "R1");
        for (int i = 0; i < 8; i++) do_read(8'(32 + 4 * i), 32'h0, "R1");
        @(negedge clk);
        check(rd_valid === 1'b0 && rd_data === 32'h0, "R9", rd_data, 32'h0);

        // R2/R3/R9: ascending and descending exhaustive sweeps
        load_key(mk_key(1));
        sweep(1'b0, "R2");
        sweep(1'b1, "R3");
        // R4: new key readable again, descending first
        load_key(mk_key(2));
        sweep(1'b1, "R4");
        sweep(1'b0, "R3");

        // R3: word-by-word reverse order, double reads interleaved
        load_key(mk_key(3));
        for (int i = 7; i >= 0; i--) begin
            do_read(8'(32 + 4 * i), cur_key[32*i +: 32], "R3");
            do_read(8'(32 + 4 * i), 32'h0, "R3");
        end

        // R8: read in the load cycle, old word unread then consumed
        load_key(mk_key(4));
        @(negedge clk);
        key_load = 1'b1; key_in = mk_key(5); rd_en = 1'b1; rd_addr = 8'h2C;
        @(negedge clk);
        key_load = 1'b0; rd_en = 1'b0;
        check(rd_valid === 1'b1 && rd_data === cur_key[32*3 +: 32], "R8", rd_data, cur_key[32*3 +: 32]);
        cur_key = mk_key(5);
        for (int i = 0; i < 8; i++) got[i] = 1'b0;
        do_read(8'h2C, cur_key[32*3 +: 32], "R8");
        @(negedge clk);
        key_load = 1'b1; key_in = mk_key(6); rd_en = 1'b1; rd_addr = 8'h2C;
        @(negedge clk);
        key_load = 1'b0; rd_en = 1'b0;
        check(rd_valid === 1'b1 && rd_data === 32'h0, "R8", rd_data, 32'h0);
        cur_key = mk_key(6);
        do_read(8'h2C, cur_key[32*3 +: 32], "R8");

        // R5/R6: writes with bit 16 clear do nothing
        do_write(8'h4C, 32'hFFFE_FFFF);
        do_read(8'h4C, 32'h0, "R6");
        do_write(8'h48, 32'h0001_0000);
        do_read(8'h4C, 32'h0, "R5");
        do_read(8'h20, cur_key[31:0], "R5");

        // R10: lock write and key read on the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h4C; wr_data = 32'h0001_0000;
        rd_en = 1'b1; rd_addr = 8'h24;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; locked = 1'b1;
        check(rd_valid === 1'b1 && rd_data === cur_key[63:32], "R10", rd_data, cur_key[63:32]);
        do_read(8'h4C, 32'h0001_0000, "R5");

        // R7: all key words zero while locked, even unread ones
        for (int i = 0; i < 8; i++) do_read(8'(32 + 4 * i), 32'h0, "R7");
        do_write(8'h4C, 32'h0);
        do_read(8'h4C, 32'h0001_0000, "R6");
        load_key(mk_key(7));
        for (int i = 0; i < 8; i++) do_read(8'(32 + 4 * i), 32'h0, "R7");
        sweep(1'b0, "R7");

        // R6/R1: only reset clears the lock
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; locked = 1'b0;
        do_read(8'h4C, 32'h0, "R6");
        do_read(8'h3C, 32'h0, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule